// File: doc/BRIEF.md
# Intrusion Alarm Sequencer

This block is the control core of a household intrusion alarm. A press of the arming button starts an exit countdown so the occupant can leave. When the countdown ends the system is armed and watches a group of sensor lines. A door reed contact or a movement detector pulls its line low when it is disturbed. The first disturbance starts an entry countdown. During that time the occupant can type a four-digit disarm code on a keypad.

A correct code returns the block to its idle, disarmed state. The alarm output turns on in two cases: the entry countdown runs out, or too many wrong codes are typed. Once the alarm sounds, it stays on until a correct code is entered or reset is asserted. All durations are counted in pulses of a one-second tick input. The countdown lengths, the number of allowed wrong attempts, the stored code and the sensor count are parameters.

Top module: `intrusion_guard`

## Requirements
- R1: Reset (synchronous, active high) drives armed_o, entry_wait_o and siren_o low, returns the controller to idle and clears the wrong-attempt count. A later entry window accepts the full number of wrong attempts again.
- R2: A one-cycle arm_press_i in idle starts the exit countdown. armed_o rises in the cycle after the EXIT_SECS-th sec_tick_i pulse and not before. Sensor activity during the countdown does not raise entry_wait_o.
- R3: Each bit of sensor_n_i is an active-low sensor line and passes through a two-flop synchroniser. While armed and idle-watching, a line held low raises entry_wait_o three clock edges after it first goes low, whichever line it is.
- R4: A code is four digits on key_digit_i (4 bits each), each marked by a one-cycle key_valid_i, with the first digit the most significant nibble of CODE. Digits are only collected while entry_wait_o or siren_o is high. Digits typed at any other time are discarded and do not join a later code.
- R5: A correct code typed while entry_wait_o is high drops all three outputs two clock edges after the edge that takes the fourth digit.
- R6: If the ENTRY_SECS-th tick of the entry window arrives without a correct code, siren_o rises and entry_wait_o falls in the cycle after that tick.
- R7: Each wrong code in the entry window adds one to the attempt count. The MAX_TRIES-th wrong code raises siren_o two edges after its fourth digit, before the window ends. Fewer wrong codes leave entry_wait_o high.
- R8: Once high, siren_o stays high through further ticks and wrong codes. Only a correct code (R5 timing) or reset clears it.
- R9: armed_o is high whenever entry_wait_o or siren_o is high. entry_wait_o and siren_o are never high together.
- R10: arm_press_i has no effect except in idle. Pressing it while armed neither drops armed_o nor restarts the exit countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_press_i | input | 1 | One-cycle arming button press |
| sensor_n_i | input | N_SENSORS | Sensor lines, low = activated |
| key_digit_i | input | DIGIT_W | Keypad digit value |
| key_valid_i | input | 1 | One-cycle strobe marking a digit |
| sec_tick_i | input | 1 | One-cycle pulse each second |
| armed_o | output | 1 | System armed (watching, pending or sounding) |
| entry_wait_o | output | 1 | Entry window open, code awaited |
| siren_o | output | 1 | Audible alarm drive |

## Verification
Each output has a fixed delay after the input that causes it. A tick that ends a countdown shows on the outputs one edge later. A sensor line going low shows three edges later: two synchroniser flops and then the state register. A code verdict shows two edges after the fourth digit is captured, because the verdict is registered and then the state changes. The bench drives inputs on falling edges. It waits exactly those edge counts before it samples {armed, pending, siren}, so a result one cycle early or late is reported.

// File: rtl/guard_pkg.sv
package guard_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_EXIT  = 3'd1,
      ST_WATCH = 3'd2,
      ST_ENTRY = 3'd3,
      ST_SOUND = 3'd4
   } guard_state_t;
endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("guard_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/guard_keypad.sv
module guard_keypad #(
   parameter int DIGITS  = 4,
   parameter int DIGIT_W = 4,
   parameter logic [DIGITS*DIGIT_W-1:0] CODE = 16'h2580
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               listen_i,
   input  logic               strobe_i,
   input  logic [DIGIT_W-1:0] digit_i,
   output logic               good_o,
   output logic               bad_o
);
   localparam int CODE_W = DIGITS * DIGIT_W;
   localparam int PRE_W  = (DIGITS - 1) * DIGIT_W;
   localparam int CNT_W  = $clog2(DIGITS + 1);

   if (DIGITS < 2) begin : g_bad_digits
      $error("guard_keypad: DIGITS must be at least 2");
   end

   logic [PRE_W-1:0]  pre_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] cand_w;
   logic              last_w;

   assign cand_w = {pre_q, digit_i};
   assign last_w = (cnt_q == CNT_W'(DIGITS - 1));

   always_ff @(posedge clk) begin
      if (rst || !listen_i) begin
         pre_q  <= '0;
         cnt_q  <= '0;
         good_o <= 1'b0;
         bad_o  <= 1'b0;
      end else begin
         good_o <= 1'b0;
         bad_o  <= 1'b0;
         if (strobe_i) begin
            if (last_w) begin
               good_o <= (cand_w == CODE);
               bad_o  <= (cand_w != CODE);
               cnt_q  <= '0;
               pre_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               pre_q <= cand_w[PRE_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_i)   cnt_q <= '0;
      else if (tick_i)     cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && tick_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/intrusion_guard.sv
module intrusion_guard
   import guard_pkg::*;
#(
   parameter int N_SENSORS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_LOW  = 1'b1,
   parameter int DIGITS      = 4,
   parameter int DIGIT_W     = 4,
   parameter logic [DIGITS*DIGIT_W-1:0] CODE = 16'h2580,
   parameter int EXIT_SECS   = 20,
   parameter int ENTRY_SECS  = 10,
   parameter int MAX_TRIES   = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 arm_press_i,
   input  logic [N_SENSORS-1:0] sensor_n_i,
   input  logic [DIGIT_W-1:0]   key_digit_i,
   input  logic                 key_valid_i,
   input  logic                 sec_tick_i,
   output logic                 armed_o,
   output logic                 entry_wait_o,
   output logic                 siren_o
);
   localparam int LONGEST = (EXIT_SECS > ENTRY_SECS) ? EXIT_SECS : ENTRY_SECS;
   localparam int TMR_W   = $clog2(LONGEST + 1);
   localparam int TRY_W   = $clog2(MAX_TRIES + 1);

   if (EXIT_SECS < 1 || ENTRY_SECS < 1) begin : g_bad_delay
      $error("intrusion_guard: delays must be at least one tick");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("intrusion_guard: MAX_TRIES must be at least 1");
   end
   if (N_SENSORS < 1) begin : g_bad_sensors
      $error("intrusion_guard: need at least one sensor");
   end

   guard_state_t         st_q, st_d;
   logic [TRY_W-1:0]     tries_q, tries_d;
   logic [N_SENSORS-1:0] sync_w, hit_w;
   logic                 code_good, code_bad, listen_w;
   logic                 t_run, t_done;
   logic [TMR_W-1:0]     t_limit;

   guard_sync #(.W(N_SENSORS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst (rst), .d_i (sensor_n_i), .q_o (sync_w)
   );

   if (ACTIVE_LOW) begin : g_low
      assign hit_w = ~sync_w;
   end else begin : g_high
      assign hit_w = sync_w;
   end

   assign listen_w = (st_q == ST_ENTRY) || (st_q == ST_SOUND);

   guard_keypad #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .CODE(CODE)) u_keys (
      .clk (clk), .rst (rst), .listen_i (listen_w),
      .strobe_i (key_valid_i), .digit_i (key_digit_i),
      .good_o (code_good), .bad_o (code_bad)
   );

   assign t_run   = (st_q == ST_EXIT) || (st_q == ST_ENTRY);
   assign t_limit = (st_q == ST_EXIT) ? TMR_W'(EXIT_SECS) : TMR_W'(ENTRY_SECS);

   guard_timer #(.CNT_W(TMR_W)) u_timer (
      .clk (clk), .rst (rst), .run_i (t_run), .tick_i (sec_tick_i),
      .limit_i (t_limit), .done_o (t_done)
   );

   always_comb begin
      st_d    = st_q;
      tries_d = tries_q;
      unique case (st_q)
         ST_IDLE: begin
            tries_d = '0;
            if (arm_press_i) st_d = ST_EXIT;
         end
         ST_EXIT: begin
            if (t_done) st_d = ST_WATCH;
         end
         ST_WATCH: begin
            if (|hit_w) st_d = ST_ENTRY;
         end
         ST_ENTRY: begin
            if (code_good) begin
               st_d = ST_IDLE;
            end else begin
               if (code_bad) begin
                  tries_d = tries_q + 1'b1;
                  if (tries_q == TRY_W'(MAX_TRIES - 1)) st_d = ST_SOUND;
               end
               if (t_done) st_d = ST_SOUND;
            end
         end
         ST_SOUND: begin
            if (code_good) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         tries_q <= '0;
      end else begin
         st_q    <= st_d;
         tries_q <= tries_d;
      end
   end

   assign armed_o      = (st_q == ST_WATCH) || (st_q == ST_ENTRY) || (st_q == ST_SOUND);
   assign entry_wait_o = (st_q == ST_ENTRY);
   assign siren_o      = (st_q == ST_SOUND);
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
   parameter int MAX_TRIES = 3,
   parameter int TRY_W     = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             sec_tick_i,
   input logic             armed_o,
   input logic             entry_wait_o,
   input logic             siren_o,
   input logic             code_good,
   input logic [TRY_W-1:0] tries_q
);
   p_siren_armed_r9: assert property (@(posedge clk) disable iff (rst)
      siren_o |-> armed_o);

   p_wait_armed_r9: assert property (@(posedge clk) disable iff (rst)
      entry_wait_o |-> armed_o);

   p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
      !(entry_wait_o && siren_o));

   p_arm_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(armed_o) |-> $past(sec_tick_i));

   p_wait_from_watch_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(entry_wait_o) |-> ($past(armed_o) && !$past(siren_o)));

   p_siren_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (siren_o && !code_good) |=> siren_o);

   p_disarm_on_code_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(armed_o) |-> $past(code_good));

   p_tries_bound_r7: assert property (@(posedge clk) disable iff (rst)
      tries_q <= TRY_W'(MAX_TRIES));
endmodule

bind intrusion_guard guard_checker #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .sec_tick_i   (sec_tick_i),
   .armed_o      (armed_o),
   .entry_wait_o (entry_wait_o),
   .siren_o      (siren_o),
   .code_good    (code_good),
   .tries_q      (tries_q)
);

// File: tb/sim_intrusion_guard.sv
module sim_intrusion_guard;
   localparam int          NS    = 4;
   localparam int          EXITS = 3;
   localparam int          ENTRS = 4;
   localparam int          TRIES = 3;
   localparam logic [15:0] GOOD  = 16'h2580;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          arm = 1'b0;
   logic [NS-1:0] sens = '1;
   logic [3:0]    dig = '0;
   logic          stb = 1'b0;
   logic          tick = 1'b0;
   logic          armed, pend, siren;
   int            checks = 0;
   int            errors = 0;
   bit            finished = 1'b0;

   always #10 clk = ~clk;

   intrusion_guard #(
      .N_SENSORS(NS), .CODE(GOOD), .EXIT_SECS(EXITS),
      .ENTRY_SECS(ENTRS), .MAX_TRIES(TRIES)
   ) u0 (
      .clk (clk), .rst (rst), .arm_press_i (arm), .sensor_n_i (sens),
      .key_digit_i (dig), .key_valid_i (stb), .sec_tick_i (tick),
      .armed_o (armed), .entry_wait_o (pend), .siren_o (siren)
   );

   // {sensor index, code, expected {armed, pending, siren}}
   localparam logic [20:0] VECS [6] = '{
      {2'd0, 16'h2580, 3'b000},
      {2'd1, 16'h2581, 3'b110},
      {2'd2, 16'h0000, 3'b110},
      {2'd3, 16'h2580, 3'b000},
      {2'd1, 16'h8025, 3'b110},
      {2'd2, 16'h5820, 3'b110}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [2:0] exp);
      checks++;
      if ({armed, pend, siren} !== exp) begin
         errors++;
         $display("FAIL %s got=%b exp=%b", req, {armed, pend, siren}, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; sens = '1; cyc(2); rst = 1'b0; cyc(1);
   endtask

   task automatic tick_pulse();
      tick = 1'b1; cyc(1); tick = 1'b0;
   endtask

   task automatic press();
      arm = 1'b1; cyc(1); arm = 1'b0;
   endtask

   task automatic key(input logic [3:0] d);
      dig = d; stb = 1'b1; cyc(1); stb = 1'b0;
   endtask

   task automatic enter_code(input logic [15:0] c);
      for (int i = 3; i >= 0; i--) key(c[i*4 +: 4]);
      cyc(1);
   endtask

   task automatic arm_fully();
      press();
      for (int i = 0; i < EXITS; i++) begin tick_pulse(); cyc(1); end
   endtask

   task automatic trip(input int idx);
      sens[idx] = 1'b0; cyc(3);
   endtask

   initial begin
      cyc(3);
      rst = 1'b0; cyc(1);
      chk("R1 reset state", 3'b000);

      // table walk: R3 trip on various lines, R4/R5/R7 code verdicts
      for (int v = 0; v < 6; v++) begin
         do_reset();
         arm_fully();
         trip(int'(VECS[v][20:19]));
         chk("R3 sensor raises pending", 3'b110);
         enter_code(VECS[v][18:3]);
         chk(VECS[v][2:0] == 3'b000 ? "R5 correct code" : "R7 wrong code", VECS[v][2:0]);
      end

      // R2 exit delay, sensors ignored meanwhile
      do_reset();
      press();
      sens[0] = 1'b0;
      for (int i = 0; i < EXITS - 1; i++) begin tick_pulse(); cyc(1); end
      chk("R2 not armed before last tick", 3'b000);
      tick_pulse();
      chk("R2 armed after last tick", 3'b100);
      cyc(1);
      chk("R3 held sensor trips once armed", 3'b110);
      sens = '1;
      enter_code(GOOD);
      chk("R5 disarm", 3'b000);

      // R10 arm press while armed
      do_reset();
      arm_fully();
      press();
      cyc(1);
      chk("R10 press while armed ignored", 3'b100);

      // R4 digits outside entry window discarded
      key(4'h2); key(4'h5);
      cyc(1);
      chk("R4 code in watch ignored", 3'b100);
      trip(1);
      key(4'h8); key(4'h0);
      cyc(1);
      chk("R4 stale digits not joined", 3'b110);
      key(4'h0); key(4'h0);
      cyc(1);
      chk("R4 first wrong attempt", 3'b110);
      sens = '1;
      enter_code(GOOD);
      chk("R5 disarm after partial", 3'b000);

      // R6 timeout, R8 latch
      do_reset();
      arm_fully();
      trip(2);
      for (int i = 0; i < ENTRS - 1; i++) begin tick_pulse(); cyc(1); end
      chk("R6 pending before timeout", 3'b110);
      tick_pulse();
      chk("R6 siren on timeout", 3'b101);
      for (int i = 0; i < 3; i++) begin tick_pulse(); cyc(1); end
      chk("R8 siren holds over ticks", 3'b101);
      enter_code(16'h1111);
      chk("R8 wrong code keeps siren", 3'b101);
      sens = '1;
      enter_code(GOOD);
      chk("R8 correct code clears siren", 3'b000);

      // R7 strike limit, R1 reset clears count
      do_reset();
      arm_fully();
      trip(0);
      enter_code(16'h1234);
      enter_code(16'h4321);
      chk("R7 two strikes still pending", 3'b110);
      enter_code(16'h9999);
      chk("R7 third strike sounds", 3'b101);
      do_reset();
      chk("R1 reset clears siren", 3'b000);
      arm_fully();
      trip(3);
      enter_code(16'h1234);
      enter_code(16'h4321);
      chk("R1 attempt count cleared", 3'b110);
      sens = '1;
      enter_code(GOOD);
      chk("R5 final disarm", 3'b000);

      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule